// File: doc/BRIEF.md
# Condition-Register Vector Index Sequencer

This block walks a vectorised operation across a 64-entry condition register file. It emits one register index per clock. A start pulse loads a 3-bit base field, a vector length and two mode bits. The block then streams out one element per cycle. Each element carries a valid strobe, its element number and its 6-bit register index. A one-cycle done pulse follows the last element.

In horizontal stepping the index advances by one from eight times the base. In vertical stepping the register file is viewed as an 8 × 8 square. The index then moves down a column in steps of eight and shifts to the next column after every eighth element. In scalar use a single element is produced, and its index is the base field itself.

The register file, its ports and any hazard tracking belong to the surrounding pipeline. This block only produces the index stream that drives them.

Top module: `cr_vec_seq`

## Requirements
- R1: After reset, `out_valid` and `done` are both low and stay low until a start is accepted.
- R2: A start seen while idle is accepted on that clock edge. Element 0 appears in the next cycle. Elements then follow one per cycle with `elem_num` counting 0, 1, 2 … up to length − 1, and there are no gaps.
- R3: With `is_vector`=1 and `vert_mode`=0, element i carries index (base × 8 + i) mod 64.
- R4: With `is_vector`=1 and `vert_mode`=1, element i carries index (base + (i mod 8) × 8 + (i div 8)) mod 64. For example, base 6 gives 6, 14, … 62, then 7, 15, ….
- R5: With `is_vector`=0, exactly one element is produced, with `elem_num`=0 and index equal to base, whatever `vec_len` holds.
- R6: `done` is a single-cycle pulse in the cycle after the last element. It is never high together with `out_valid`.
- R7: With `is_vector`=1 and `vec_len`=0, no element is produced and `done` pulses in the cycle after start.
- R8: A `vec_len` above 64 is treated as 64.
- R9: A start that arrives while elements are being issued, or in the done cycle, is ignored. The running sequence and its single done pulse are unchanged, and no new sequence follows.
- R10: `base_sel`, `vec_len`, `is_vector` and `vert_mode` are sampled only at an accepted start. Changing them during a sequence has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new sequence |
| base_sel | input | 3 | Base condition-register field |
| vec_len | input | 7 | Vector length, 0 to 64 (larger values clamp to 64) |
| is_vector | input | 1 | 1 = vector sequence, 0 = single scalar element |
| vert_mode | input | 1 | 1 = column (step 8) walk, 0 = linear walk |
| out_valid | output | 1 | Element strobe |
| elem_num | output | 6 | Element number of the current index |
| cr_index | output | 6 | Condition-register index for the element |
| done | output | 1 | One-cycle pulse after the final element |

## Verification
The bench uses base 7 with 64 horizontal elements and base 6 with 64 vertical elements. In both cases the index runs past 63, so a design without modulo-64 wrap would give wrong indices late in the run, and an off-by-one column carry would show up at element 8. It also covers a length of 0, a length above 64 and a scalar request with a nonzero length. A design that mishandles these would issue elements when none are wanted, stop at a truncated count, or issue a full vector where one element is required. In one scenario, start is held and the inputs are scrambled through the run and its done cycle. A design that restarts would then show extra elements, a second done pulse or indices built from the new base.

// File: rtl/cr_vec_seq.sv
module cr_vec_seq #(
  parameter int ROW_W = 3,
  localparam int IDX_W = 2 * ROW_W,
  localparam int LEN_W = IDX_W + 1,
  localparam int NREG  = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] base_sel,
  input  logic [LEN_W-1:0] vec_len,
  input  logic             is_vector,
  input  logic             vert_mode,
  output logic             out_valid,
  output logic [IDX_W-1:0] elem_num,
  output logic [IDX_W-1:0] cr_index,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  localparam logic [LEN_W-1:0] FULL = LEN_W'(NREG);

  st_t              st;
  logic [ROW_W-1:0] base_q;
  logic [IDX_W-1:0] cnt, last_q;
  logic             vec_q, vert_q;

  logic [LEN_W-1:0] len_clip;
  logic [IDX_W-1:0] last_d, h_idx, v_idx;

  assign len_clip = (vec_len > FULL) ? FULL : vec_len;
  assign last_d   = is_vector ? IDX_W'(len_clip - 1'b1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      last_q <= '0;
      base_q <= '0;
      vec_q  <= 1'b0;
      vert_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          base_q <= base_sel;
          vec_q  <= is_vector;
          vert_q <= vert_mode;
          cnt    <= '0;
          last_q <= last_d;
          st     <= (is_vector && vec_len == '0) ? S_FIN : S_RUN;
        end
        S_RUN: begin
          if (cnt == last_q) st <= S_FIN;
          else cnt <= cnt + 1'b1;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign h_idx = {base_q, {ROW_W{1'b0}}} + cnt;
  assign v_idx = IDX_W'(base_q) + {cnt[ROW_W-1:0], {ROW_W{1'b0}}}
               + IDX_W'(cnt[IDX_W-1:ROW_W]);

  assign out_valid = (st == S_RUN);
  assign done      = (st == S_FIN);
  assign elem_num  = cnt;
  assign cr_index  = !vec_q ? IDX_W'(base_q) : (vert_q ? v_idx : h_idx);
endmodule

// File: rtl/cr_vec_seq_chk.sv
module cr_vec_seq_chk #(
  parameter int ROW_W = 3,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic [IDX_W-1:0] elem_num,
  input logic [IDX_W-1:0] cr_index,
  input logic             done,
  input logic             vec_q,
  input logic             vert_q
);
  localparam logic [IDX_W-1:0] ROWSTEP = IDX_W'(1) << ROW_W;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && done));
  p_done_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> done);
  p_first_elem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> elem_num == '0);
  p_elem_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) |-> elem_num == $past(elem_num) + 1'b1);
  p_horiz_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) && vec_q && !vert_q
      |-> cr_index == $past(cr_index) + 1'b1);
  p_vert_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) && vec_q && vert_q && elem_num[ROW_W-1:0] != '0
      |-> cr_index == $past(cr_index) + ROWSTEP);
  p_scalar_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !vec_q |=> !out_valid);
endmodule

bind cr_vec_seq cr_vec_seq_chk #(.ROW_W(ROW_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .elem_num(elem_num),
  .cr_index(cr_index), .done(done), .vec_q(vec_q), .vert_q(vert_q)
);

// File: tb/tb_cr_vec_seq.sv
`timescale 1ns/1ps
module tb_cr_vec_seq;
  logic       clk = 0, rst_n = 0, start = 0;
  logic [2:0] base_sel = 0;
  logic [6:0] vec_len = 0;
  logic       is_vector = 0, vert_mode = 0;
  logic       out_valid, done;
  logic [5:0] elem_num, cr_index;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  cr_vec_seq dut (.clk(clk), .rst_n(rst_n), .start(start), .base_sel(base_sel),
    .vec_len(vec_len), .is_vector(is_vector), .vert_mode(vert_mode),
    .out_valid(out_valid), .elem_num(elem_num), .cr_index(cr_index), .done(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_idx(int b, int i, bit vec, bit vert);
    if (!vec) return b;
    if (vert) return (b + (i % 8) * 8 + i / 8) % 64;
    return (b * 8 + i) % 64;
  endfunction

  task automatic run_seq(input int b, input int vl, input bit vec, input bit vert,
                         input bit disturb, input string req);
    int n;
    n = !vec ? 1 : (vl > 64 ? 64 : vl);
    @(negedge clk);
    start = 1; base_sel = 3'(b); vec_len = 7'(vl); is_vector = vec; vert_mode = vert;
    @(negedge clk);
    start = disturb;
    for (int k = 0; k < n; k++) begin
      if (disturb) begin
        base_sel = 3'(b + 3); vec_len = 7'd5; is_vector = ~vec; vert_mode = ~vert;
      end
      check(out_valid === 1'b1, {req, " valid"}, int'(out_valid), 1);
      check(elem_num == 6'(k), {req, " elem (R2)"}, int'(elem_num), k);
      check(int'(cr_index) == exp_idx(b, k, vec, vert), {req, " index"},
            int'(cr_index), exp_idx(b, k, vec, vert));
      check(done === 1'b0, {req, " done early (R6)"}, int'(done), 0);
      @(negedge clk);
    end
    check(done === 1'b1 && out_valid === 1'b0, {req, " done pulse (R6)"}, int'(done), 1);
    @(negedge clk);
    start = 0;
    check(done === 1'b0, {req, " done single (R6)"}, int'(done), 0);
    check(out_valid === 1'b0, {req, " no restart (R9)"}, int'(out_valid), 0);
    @(negedge clk);
    check(out_valid === 1'b0 && done === 1'b0, {req, " idle (R9)"}, int'(out_valid), 0);
  endtask

  task automatic t_reset;
    check(out_valid === 1'b0, "R1 valid at reset", int'(out_valid), 0);
    check(done === 1'b0, "R1 done at reset", int'(done), 0);
  endtask

  task automatic t_horiz;
    run_seq(0, 8, 1, 0, 0, "R3 horiz base0");
    run_seq(7, 64, 1, 0, 0, "R3 horiz wrap base7");
  endtask

  task automatic t_vert;
    run_seq(6, 16, 1, 1, 0, "R4 vert base6");
    run_seq(6, 64, 1, 1, 0, "R4 vert wrap base6");
  endtask

  task automatic t_scalar;
    run_seq(5, 9, 0, 0, 0, "R5 scalar len9");
    run_seq(2, 0, 0, 1, 0, "R5 scalar len0");
  endtask

  task automatic t_zero_len;
    @(negedge clk);
    start = 1; base_sel = 3; vec_len = 0; is_vector = 1; vert_mode = 0;
    @(negedge clk);
    start = 0;
    check(out_valid === 1'b0, "R7 no element", int'(out_valid), 0);
    check(done === 1'b1, "R7 done after start", int'(done), 1);
    @(negedge clk);
    check(done === 1'b0 && out_valid === 1'b0, "R7 done single", int'(done), 0);
  endtask

  task automatic t_clamp;
    run_seq(1, 100, 1, 0, 0, "R8 clamp len100");
  endtask

  task automatic t_disturb;
    run_seq(3, 10, 1, 1, 1, "R9 R10 disturb vert");
    run_seq(4, 12, 1, 0, 1, "R9 R10 disturb horiz");
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    start = 1; is_vector = 1; vec_len = 4;
    @(negedge clk);
    t_reset();
    start = 0;
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_horiz();
    t_vert();
    t_scalar();
    t_zero_len();
    t_clamp();
    t_disturb();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule